// File: doc/BRIEF.md
# Serial Wire Debug Host Transaction Engine

This block is the host end of a two-wire debug link. It takes one command at a time and runs a single Serial Wire Debug transaction on the line. A command gives the access-port or debug-port select, the read/write flag, two register-address bits and a 32-bit write word. The engine makes the serial clock from the system clock with a programmable divider and drives the data line through an output-enable. It reads the line back while the target owns it. When the transaction ends, it returns the target's acknowledge, any read word and two flags: a read-parity mismatch and no response from the target.

The engine builds the request frame and its parity. It places the turnaround slots where the direction changes, and that placement differs for reads and writes. It moves the data phase only after an OK acknowledge and closes every transaction with a run of clocks with the line held low. Retry decisions, line resets and link bring-up belong to the requester that sits above the engine.

A bit slot here means one serial clock period. It starts low and ends on the next falling edge. The host changes the line at the start of a slot and samples it on the rising edge in the middle.

Top module: `swdh_engine`

## Requirements
- R1: A command is accepted in a system cycle where `cmd_valid` and `cmd_ready` are both high. The first 8 slots then carry the request with the host driving, slot 0 first: 1, select (0 = debug port), read flag (1 = read), `cmd_addr[0]`, `cmd_addr[1]`, parity, 0, 1. The parity bit is the XOR of the select, read flag and both address bits.
- R2: Slot 8 is a turnaround with `swdio_oe` low. Slots 9 to 11 are sampled as the acknowledge, with `swdio_oe` low. The first bit sampled becomes bit 0 of `rsp_ack`, so OK = 3'b001, WAIT = 3'b010 and FAULT = 3'b100.
- R3: On a write with OK, slot 12 is a turnaround with `swdio_oe` low. Slots 13 to 44 then drive the write word LSB first, and slot 45 drives its parity, which is 1 when the word has an odd number of ones.
- R4: On a read with OK, the host keeps `swdio_oe` low over slots 12 to 45. It samples the word LSB first in slots 12 to 43 and the parity in slot 44, and returns the word on `rsp_rdata`. Slot 45 is the turnaround.
- R5: On a read with OK, `rsp_perr` is 1 exactly when the sampled parity differs from the XOR of the sampled word. The word is returned in either case.
- R6: Every transaction ends with IDLE_CYC slots (default 8) with `swdio_oe` high and `swdio_out` low. A one-cycle `rsp_valid` pulse follows, with `cmd_ready` high. An OK transaction therefore lasts 46+IDLE_CYC slots.
- R7: On WAIT or FAULT, no data phase runs. Slot 12 is a turnaround and the trailing idle slots follow, so the transaction lasts 13+IDLE_CYC slots. The response carries the sampled acknowledge, `rsp_noresp`=0 and `rsp_rdata`=0.
- R8: An acknowledge other than OK, WAIT or FAULT gives the same frame shape as R7, with `rsp_noresp`=1, `rsp_perr`=0 and `rsp_rdata`=0.
- R9: `swclk` rests low while `cmd_ready` is high. Each half period is HALF_DIV system cycles. `swdio_out` and `swdio_oe` change only while `swclk` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_apndp | input | 1 | 1 selects the access port, 0 the debug port |
| cmd_rnw | input | 1 | 1 for read, 0 for write |
| cmd_addr | input | 2 | Register address bits, bit 0 sent first |
| cmd_wdata | input | 32 | Write word |
| rsp_valid | output | 1 | One-cycle pulse at the end of a transaction |
| rsp_ack | output | 3 | Sampled acknowledge, first bit in bit 0 |
| rsp_rdata | output | 32 | Read word, zero unless a read with OK |
| rsp_perr | output | 1 | Read parity mismatch |
| rsp_noresp | output | 1 | Acknowledge not a known code |
| swclk | output | 1 | Serial clock to the target |
| swdio_out | output | 1 | Host data value |
| swdio_oe | output | 1 | Host drives the data line when high |
| swdio_in | input | 1 | Data line as seen at the pin |

## Verification
The bench acts as the target. It records the line state in every slot and answers with chosen acknowledges and read words. That lets it catch a turnaround misplaced between read and write, which would show up as the host driving in the slot after the acknowledge or releasing one slot late. A wrong request parity or bit order shows as a mismatched frame. A read with corrupted parity has to raise the flag and still return the word. A design that drops the word, or flags good parity, fails that check. Tests with WAIT, FAULT, all-ones and all-zeros acknowledges check that no data phase runs and that the slot count is right. A line held high during unused slots would expose an engine that samples when it should not.

// File: rtl/swdh_pkg.sv
package swdh_pkg;
    localparam int SWDH_DW = 32;

    localparam logic [2:0] ACK_OK    = 3'b001;
    localparam logic [2:0] ACK_WAIT  = 3'b010;
    localparam logic [2:0] ACK_FAULT = 3'b100;

    typedef enum logic [2:0] {
        ST_IDLE, ST_REQ, ST_TRN1, ST_ACK, ST_TRN2, ST_WDATA, ST_RDATA, ST_TAIL
    } swdh_state_e;

    typedef struct packed {
        logic               apndp;
        logic               rnw;
        logic [1:0]         addr;
        logic [SWDH_DW-1:0] wdata;
    } swdh_cmd_t;

    typedef struct packed {
        logic [2:0]         ack;
        logic [SWDH_DW-1:0] rdata;
        logic               perr;
        logic               noresp;
    } swdh_rsp_t;

    // request frame, bit 0 leaves the host first
    function automatic logic [7:0] build_request(swdh_cmd_t c);
        logic par;
        par = c.apndp ^ c.rnw ^ c.addr[0] ^ c.addr[1];
        return {1'b1, 1'b0, par, c.addr[1], c.addr[0], c.rnw, c.apndp, 1'b1};
    endfunction

    function automatic logic ack_known(logic [2:0] a);
        return (a == ACK_OK) || (a == ACK_WAIT) || (a == ACK_FAULT);
    endfunction
endpackage

// File: rtl/swdh_clkgen.sv
module swdh_clkgen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic swclk,
    output logic rise,
    output logic fall
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt;
    logic          tick;

    assign tick = run && (cnt == CW'(HALF_DIV - 1));
    assign rise = tick && !swclk;
    assign fall = tick && swclk;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt   <= '0;
            swclk <= 1'b0;
        end else if (tick) begin
            cnt   <= '0;
            swclk <= !swclk;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // a stopped clock must rest low
    assert_stop_low_R9: assert property (@(posedge clk) disable iff (rst)
        !run |=> !swclk);
endmodule

// File: rtl/swdh_seq.sv
module swdh_seq
    import swdh_pkg::*;
#(
    parameter int IDLE_CYC = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      cmd_valid,
    input  swdh_cmd_t cmd,
    output logic      idle,
    input  logic      rise,
    input  logic      fall,
    input  logic      sdi,
    output logic      sdo,
    output logic      sdo_oe,
    output logic      rsp_valid,
    output swdh_rsp_t rsp
);
    localparam int DW    = SWDH_DW;
    localparam int MAXC  = (DW + 1 > IDLE_CYC) ? DW + 1 : IDLE_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);

    swdh_state_e      state;
    logic [CNT_W-1:0] cnt;
    logic [7:0]       req_sr;
    logic [DW:0]      wd_sr;
    logic [DW:0]      rd_sr;
    logic [2:0]       ack_r;
    logic             rnw_r;
    logic             ack_ok;

    assign idle   = (state == ST_IDLE);
    assign ack_ok = (ack_r == ACK_OK);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            req_sr    <= '0;
            wd_sr     <= '0;
            rd_sr     <= '0;
            ack_r     <= '0;
            rnw_r     <= 1'b0;
            sdo       <= 1'b0;
            sdo_oe    <= 1'b1;
            rsp_valid <= 1'b0;
            rsp       <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (state == ST_IDLE) begin
                if (cmd_valid) begin
                    req_sr <= build_request(cmd);
                    wd_sr  <= {^cmd.wdata, cmd.wdata};
                    rnw_r  <= cmd.rnw;
                    sdo    <= 1'b1;
                    sdo_oe <= 1'b1;
                    cnt    <= '0;
                    state  <= ST_REQ;
                end
            end else begin
                if (rise) begin
                    if (state == ST_ACK)   ack_r <= {sdi, ack_r[2:1]};
                    if (state == ST_RDATA) rd_sr <= {sdi, rd_sr[DW:1]};
                end
                if (fall) begin
                    case (state)
                        ST_REQ: begin
                            if (cnt == CNT_W'(7)) begin
                                state  <= ST_TRN1;
                                sdo_oe <= 1'b0;
                                sdo    <= 1'b0;
                                cnt    <= '0;
                            end else begin
                                req_sr <= req_sr >> 1;
                                sdo    <= req_sr[1];
                                cnt    <= cnt + 1'b1;
                            end
                        end
                        ST_TRN1: begin
                            state <= ST_ACK;
                            cnt   <= '0;
                        end
                        ST_ACK: begin
                            if (cnt == CNT_W'(2)) begin
                                cnt   <= '0;
                                state <= (ack_ok && rnw_r) ? ST_RDATA : ST_TRN2;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                        ST_RDATA: begin
                            if (cnt == CNT_W'(DW)) begin
                                state <= ST_TRN2;
                                cnt   <= '0;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                        ST_TRN2: begin
                            cnt    <= '0;
                            sdo_oe <= 1'b1;
                            if (ack_ok && !rnw_r) begin
                                state <= ST_WDATA;
                                sdo   <= wd_sr[0];
                            end else begin
                                state <= ST_TAIL;
                                sdo   <= 1'b0;
                            end
                        end
                        ST_WDATA: begin
                            if (cnt == CNT_W'(DW)) begin
                                state <= ST_TAIL;
                                sdo   <= 1'b0;
                                cnt   <= '0;
                            end else begin
                                wd_sr <= wd_sr >> 1;
                                sdo   <= wd_sr[1];
                                cnt   <= cnt + 1'b1;
                            end
                        end
                        ST_TAIL: begin
                            if (cnt == CNT_W'(IDLE_CYC - 1)) begin
                                state      <= ST_IDLE;
                                cnt        <= '0;
                                rsp_valid  <= 1'b1;
                                rsp.ack    <= ack_r;
                                rsp.noresp <= !ack_known(ack_r);
                                rsp.rdata  <= (ack_ok && rnw_r) ? rd_sr[DW-1:0] : '0;
                                rsp.perr   <= ack_ok && rnw_r &&
                                              ((^rd_sr[DW-1:0]) != rd_sr[DW]);
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                        default: state <= ST_IDLE;
                    endcase
                end
            end
        end
    end

    assert_trn_release_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TRN1 || state == ST_ACK) |-> !sdo_oe);

    assert_rdata_released_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RDATA) |-> !sdo_oe);

    assert_noresp_clean_R8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp.noresp) |-> (rsp.rdata == '0 && !rsp.perr));
endmodule

// File: rtl/swdh_engine.sv
module swdh_engine
    import swdh_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int IDLE_CYC = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic               cmd_apndp,
    input  logic               cmd_rnw,
    input  logic [1:0]         cmd_addr,
    input  logic [SWDH_DW-1:0] cmd_wdata,
    output logic               rsp_valid,
    output logic [2:0]         rsp_ack,
    output logic [SWDH_DW-1:0] rsp_rdata,
    output logic               rsp_perr,
    output logic               rsp_noresp,
    output logic               swclk,
    output logic               swdio_out,
    output logic               swdio_oe,
    input  logic               swdio_in
);
    swdh_cmd_t cmd;
    swdh_rsp_t rsp;
    logic      idle, rise, fall;

    assign cmd = '{apndp: cmd_apndp, rnw: cmd_rnw, addr: cmd_addr, wdata: cmd_wdata};

    swdh_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
        .clk(clk), .rst(rst), .run(!idle),
        .swclk(swclk), .rise(rise), .fall(fall)
    );

    swdh_seq #(.IDLE_CYC(IDLE_CYC)) u_seq (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd), .idle(idle),
        .rise(rise), .fall(fall), .sdi(swdio_in), .sdo(swdio_out),
        .sdo_oe(swdio_oe), .rsp_valid(rsp_valid), .rsp(rsp)
    );

    assign cmd_ready  = idle;
    assign rsp_ack    = rsp.ack;
    assign rsp_rdata  = rsp.rdata;
    assign rsp_perr   = rsp.perr;
    assign rsp_noresp = rsp.noresp;

    assert_stable_high_R9: assert property (@(posedge clk) disable iff (rst)
        (swclk && $past(swclk)) |-> ($stable(swdio_out) && $stable(swdio_oe)));

    assert_idle_low_R9: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> !swclk);

    assert_rsp_idle_R6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> cmd_ready);
endmodule

// File: tb/sim_swdh_engine.sv
module sim_swdh_engine;
    localparam int HALF = 2;
    localparam int IDLE = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_apndp = 1'b0;
    logic        cmd_rnw = 1'b0;
    logic [1:0]  cmd_addr = 2'b00;
    logic [31:0] cmd_wdata = '0;
    logic        swdio_in = 1'b1;
    logic        cmd_ready, rsp_valid, rsp_perr, rsp_noresp;
    logic [2:0]  rsp_ack;
    logic [31:0] rsp_rdata;
    logic        swclk, swdio_out, swdio_oe;

    int checks = 0;
    int fails  = 0;

    // target model state
    int          mslot = 0;
    logic        obs_out [0:63];
    logic        obs_oe  [0:63];
    time         rise_t  [0:1];
    logic [2:0]  t_ack = 3'b001;
    logic [31:0] t_rdata = '0;
    logic        t_dread = 1'b0;
    logic        t_corrupt = 1'b0;

    always #2 clk = !clk;

    swdh_engine #(.HALF_DIV(HALF), .IDLE_CYC(IDLE)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_apndp(cmd_apndp), .cmd_rnw(cmd_rnw), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid), .rsp_ack(rsp_ack),
        .rsp_rdata(rsp_rdata), .rsp_perr(rsp_perr), .rsp_noresp(rsp_noresp),
        .swclk(swclk), .swdio_out(swdio_out), .swdio_oe(swdio_oe),
        .swdio_in(swdio_in)
    );

    always @(posedge swclk) begin
        #1;
        if (mslot < 64) begin
            obs_out[mslot] = swdio_out;
            obs_oe[mslot]  = swdio_oe;
        end
        if (mslot < 2) rise_t[mslot] = $time;
        mslot = mslot + 1;
    end

    always @(negedge swclk) begin
        #1;
        if (mslot >= 9 && mslot <= 11)               swdio_in = t_ack[mslot-9];
        else if (t_dread && mslot >= 12 && mslot < 44) swdio_in = t_rdata[mslot-12];
        else if (t_dread && mslot == 44)             swdio_in = (^t_rdata) ^ t_corrupt;
        else                                         swdio_in = 1'b1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_txn(input logic apndp, input logic rnw, input logic [1:0] addr,
                           input logic [31:0] wdata, input logic [2:0] ack,
                           input logic [31:0] rdata, input logic corrupt);
        logic [7:0]  exp_req, got_req;
        logic [32:0] got_w;
        logic        ok, req_oe, rel, idle_ok;
        int          exp_slots;
        ok        = (ack == 3'b001);
        t_ack     = ack;
        t_rdata   = rdata;
        t_dread   = ok && rnw;
        t_corrupt = corrupt;
        mslot     = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_apndp = apndp; cmd_rnw = rnw;
        cmd_addr = addr; cmd_wdata = wdata;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        do begin @(posedge clk); #1; end while (!rsp_valid);

        // R1 request frame
        exp_req = {1'b1, 1'b0, apndp ^ rnw ^ addr[0] ^ addr[1], addr[1], addr[0], rnw, apndp, 1'b1};
        req_oe = 1'b1;
        for (int i = 0; i < 8; i++) begin got_req[i] = obs_out[i]; req_oe &= obs_oe[i]; end
        chk(got_req == exp_req && req_oe, "R1", "request bits", 64'(got_req), 64'(exp_req));
        // R2 turnaround and acknowledge
        chk(!obs_oe[8] && !obs_oe[9] && !obs_oe[10] && !obs_oe[11], "R2", "released trn/ack",
            64'({obs_oe[8], obs_oe[9], obs_oe[10], obs_oe[11]}), 64'(0));
        chk(rsp_ack == ack, "R2", "rsp_ack", 64'(rsp_ack), 64'(ack));
        if (ok) exp_slots = 46 + IDLE; else exp_slots = 13 + IDLE;
        chk(mslot == exp_slots, "R6", "slot count", 64'(mslot), 64'(exp_slots));
        if (ok && !rnw) begin
            got_w = '0;
            rel = obs_oe[12];
            for (int i = 0; i < 33; i++) begin got_w[i] = obs_out[13+i]; rel |= !obs_oe[13+i]; end
            chk(!rel, "R3", "write oe pattern", 64'(rel), 64'(0));
            chk(got_w == {^wdata, wdata}, "R3", "write data+parity", 64'(got_w), 64'({^wdata, wdata}));
        end
        if (ok && rnw) begin
            rel = 1'b0;
            for (int i = 12; i < 46; i++) rel |= obs_oe[i];
            chk(!rel, "R4", "read slots released", 64'(rel), 64'(0));
            chk(rsp_rdata == rdata, "R4", "rsp_rdata", 64'(rsp_rdata), 64'(rdata));
            chk(rsp_perr == corrupt, "R5", "rsp_perr", 64'(rsp_perr), 64'(corrupt));
        end
        if (!ok) begin
            chk(!obs_oe[12], "R7", "turnaround after non-OK ack", 64'(obs_oe[12]), 64'(0));
            chk(rsp_rdata == 0 && !rsp_perr, "R7", "no data on non-OK", 64'(rsp_rdata), 64'(0));
        end
        chk(rsp_noresp == !(ack == 3'b001 || ack == 3'b010 || ack == 3'b100), "R8", "rsp_noresp",
            64'(rsp_noresp), 64'(!(ack == 3'b001 || ack == 3'b010 || ack == 3'b100)));
        idle_ok = 1'b1;
        for (int i = mslot - IDLE; i < mslot; i++) idle_ok &= obs_oe[i] && !obs_out[i];
        chk(idle_ok, "R6", "trailing idle low", 64'(idle_ok), 64'(1));
        chk(cmd_ready && !swclk, "R9", "idle clock low/ready", 64'({cmd_ready, swclk}), 64'(2'b10));
        chk(rise_t[1] - rise_t[0] == 2 * HALF * 4, "R9", "swclk period",
            64'(rise_t[1] - rise_t[0]), 64'(2 * HALF * 4));
        @(posedge clk); #1;
        chk(!rsp_valid, "R6", "rsp_valid single pulse", 64'(rsp_valid), 64'(0));
    endtask

    initial begin
        #800000;
        checks++; fails++;
        $display("FAIL watchdog expired (R6): actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(cmd_ready && !swclk && !rsp_valid && swdio_oe && !swdio_out, "R9", "reset state",
            64'({cmd_ready, swclk, rsp_valid, swdio_oe, swdio_out}), 64'(5'b10010));
        run_txn(1'b0, 1'b0, 2'b01, 32'h1234_5678, 3'b001, 32'h0, 1'b0);   // R3 write DP
        run_txn(1'b1, 1'b0, 2'b11, 32'hFFFF_FFFF, 3'b001, 32'h0, 1'b0);   // R3 even parity
        run_txn(1'b0, 1'b1, 2'b00, 32'h2BA0_1477, 3'b001, 32'h2BA0_1477, 1'b0); // R4 R5
        run_txn(1'b1, 1'b1, 2'b10, 32'h0, 3'b001, 32'h0000_0001, 1'b1);   // R5 corrupt
        run_txn(1'b1, 1'b1, 2'b01, 32'h0, 3'b010, 32'hDEAD_BEEF, 1'b0);   // R7 WAIT
        run_txn(1'b0, 1'b0, 2'b10, 32'hA5A5_0F0F, 3'b100, 32'h0, 1'b0);   // R7 FAULT
        run_txn(1'b0, 1'b1, 2'b00, 32'h0, 3'b111, 32'h0, 1'b0);           // R8 floating high
        run_txn(1'b1, 1'b0, 2'b00, 32'h0000_8000, 3'b000, 32'h0, 1'b0);   // R8 all zero
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule